// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

This block collects a set of peripheral interrupt request lines and folds them onto a smaller number of general-purpose event lines for a processor core. Each source has a bit in three per-source registers: an enable mask that decides whether the source may drive its event line, a read-only status view of the raw request, and a wakeup enable that lets the source wake a powered-down core.

Every event line feeds a rising-edge detector and a pending latch. The latch is set two clock edges after a rising edge and stays set until the core raises that event's acknowledge. While the acknowledge stays high, the detector keeps watching, so a fresh rising edge is latched again and waits for the next acknowledge.

Several sources can share one event line. The status register lets software see which of them is requesting. The routing from source to event is fixed when the block is built: source `s` drives event `floor(s*NUM_EVT/NUM_SRC)`.

Top module: `irq_aggregator`

## Requirements
- R1: Each `evt_line` bit is the OR, in the same cycle, of the sources routed to it whose mask bit is 1. A source whose mask bit is 0 never contributes.
- R2: A read at word address 1 returns `periph_req` in the same cycle, whatever the mask and wakeup bits hold.
- R3: Word address 0 holds the mask and word address 2 holds the wakeup enables. A write with `reg_wr` high takes effect at the clock edge and reads back from the next cycle. Address 3 reads as zero.
- R4: A write to address 1 changes neither the mask nor the wakeup enables.
- R5: `wake_out` is 1 exactly when `core_asleep` is 1 and at least one source with its wakeup bit set is requesting. The mask has no effect on it.
- R6: A 0-to-1 change on an event line seen at one clock edge sets that event's `evt_pend` bit at the following edge, so it reads 1 two edges after the rise.
- R7: A set `evt_pend` bit stays set until a clock edge at which its `evt_ack` is 1 after having been 0 at the edge before. It reads 0 after that edge.
- R8: While `evt_ack` stays high, a new rising edge on the same event line sets `evt_pend` again with the R6 timing. A rise that coincides with the acknowledge edge keeps the bit set.
- R9: An event line held high without a new 0-to-1 change does not set `evt_pend` again after it has been cleared.
- R10: Reset, active low and synchronous, clears the mask, the wakeup enables and all pending bits.
- R11: With the defaults (8 sources, 3 events), sources 0 to 2 drive event 0, sources 3 to 5 drive event 1, and sources 6 and 7 drive event 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | NUM_SRC | Peripheral request levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | NUM_SRC | Register write data |
| reg_rdata | output | NUM_SRC | Register read data, combinational |
| evt_ack | input | NUM_EVT | Per-event active indication from the core |
| core_asleep | input | 1 | Core is in a powered-down state |
| evt_line | output | NUM_EVT | Masked, routed event levels |
| evt_pend | output | NUM_EVT | Per-event pending latch |
| wake_out | output | 1 | Wakeup request |

## Verification
The event lines, the read data and the wakeup output are combinational, so they are due in the same cycle as their inputs. The bench drives inputs one nanosecond after a rising edge and compares at the following falling edge. Register writes count from the edge that samples the strobe, and pending bits appear two edges after the event line rises. A reference model advances on each rising edge from the inputs sampled there, and its results are compared at every falling edge. Directed checks count edges explicitly to confirm the not-yet state one edge after a rise and the set state one edge later.

// File: rtl/irq_agg_pkg.sv
// Package: shared register address codes for the interrupt aggregator.
// Assumes a two-bit word address on the register port.
package irq_agg_pkg;

    typedef enum logic [1:0] {
        REG_MASK   = 2'd0,
        REG_STATUS = 2'd1,
        REG_WAKE   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_agg_regs.sv
// Per-source register bank: mask and wakeup enables (read/write), status
// (raw request, read-only). Assumes a single-cycle write strobe and a
// combinational read path; synchronous active-low reset.
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         addr,
    input  logic [NUM_SRC-1:0] wdata,
    input  logic [NUM_SRC-1:0] periph_req,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] wake_q,
    output logic [NUM_SRC-1:0] rdata
);

    // Register update: only the mask and wakeup words are writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            wake_q <= '0;
        end else if (wr_en) begin
            if (addr == REG_MASK) mask_q <= wdata;
            if (addr == REG_WAKE) wake_q <= wdata;
        end
    end

    // Read multiplexer: status returns the live request lines.
    always_comb begin
        case (addr)
            REG_MASK:   rdata = mask_q;
            REG_STATUS: rdata = periph_req;
            REG_WAKE:   rdata = wake_q;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_agg_route.sv
// Source-to-event routing: each event line is the OR of the enabled sources
// selected by its row of a fixed routing table. Purely combinational.
module irq_agg_route #(
    parameter int                           NUM_SRC = 8,
    parameter int                           NUM_EVT = 3,
    parameter logic [NUM_EVT*NUM_SRC-1:0]   ROUTE   = '0
) (
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_SRC-1:0] mask,
    output logic [NUM_EVT-1:0] evt_line
);

    logic [NUM_SRC-1:0] enabled;

    // Gate each request with its enable bit.
    assign enabled = req & mask;

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
        // Reduce the enabled sources routed to event e.
        assign evt_line[e] = |(enabled & ROUTE[e*NUM_SRC +: NUM_SRC]);
    end

endmodule

// File: rtl/irq_agg_edge.sv
// One event's edge detector and pending latch. The line is registered twice;
// a 0-to-1 step between the stages sets the latch. The latch clears on the
// rising edge of the acknowledge, and a new rise wins over a clear in the
// same cycle. Assumes the line is synchronous to clk.
module irq_agg_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic ack,
    output logic pend
);

    logic stage1, stage2, ack_d;
    logic rise_seen, ack_rise, pend_nxt;

    // Next-state terms for the latch.
    always_comb begin
        rise_seen = stage1 & ~stage2;
        ack_rise  = ack & ~ack_d;
        pend_nxt  = rise_seen | (pend & ~ack_rise);
    end

    // History registers and the latch itself.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
            ack_d  <= 1'b0;
            pend   <= 1'b0;
        end else begin
            stage1 <= line;
            stage2 <= stage1;
            ack_d  <= ack;
            pend   <= pend_nxt;
        end
    end

endmodule

// File: rtl/irq_aggregator.sv
// Top level: register bank, routing network, one edge/pending cell per event,
// and the wakeup request. Source s is routed to event s*NUM_EVT/NUM_SRC.
// Assumes all inputs are synchronous to clk; synchronous active-low reset.
module irq_aggregator #(
    parameter int NUM_SRC = 8,
    parameter int NUM_EVT = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] periph_req,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    input  logic [NUM_EVT-1:0] evt_ack,
    input  logic               core_asleep,
    output logic [NUM_EVT-1:0] evt_line,
    output logic [NUM_EVT-1:0] evt_pend,
    output logic               wake_out
);

    // Build the routing table: one bit set per source, in its event's row.
    function automatic logic [NUM_EVT*NUM_SRC-1:0] build_route();
        logic [NUM_EVT*NUM_SRC-1:0] r;
        r = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            r[(s * NUM_EVT / NUM_SRC) * NUM_SRC + s] = 1'b1;
        end
        return r;
    endfunction

    localparam logic [NUM_EVT*NUM_SRC-1:0] ROUTE = build_route();

    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] wake_q;

    irq_agg_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .periph_req (periph_req),
        .mask_q     (mask_q),
        .wake_q     (wake_q),
        .rdata      (reg_rdata)
    );

    irq_agg_route #(.NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT), .ROUTE(ROUTE)) u_route (
        .req      (periph_req),
        .mask     (mask_q),
        .evt_line (evt_line)
    );

    for (genvar e = 0; e < NUM_EVT; e++) begin : g_cell
        irq_agg_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .line  (evt_line[e]),
            .ack   (evt_ack[e]),
            .pend  (evt_pend[e])
        );
    end

    // Wakeup request: any wake-enabled source while the core sleeps.
    assign wake_out = core_asleep & (|(periph_req & wake_q));

endmodule

// File: rtl/irq_agg_chk.sv
// Checker for irq_aggregator, attached by bind. Observes ports and the
// mask/wakeup registers; it drives nothing.
module irq_agg_chk #(
    parameter int NUM_SRC = 8,
    parameter int NUM_EVT = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] periph_req,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] wake_q,
    input logic               reg_wr,
    input logic [1:0]         reg_addr,
    input logic [NUM_EVT-1:0] evt_line,
    input logic [NUM_EVT-1:0] evt_pend,
    input logic [NUM_EVT-1:0] evt_ack,
    input logic               core_asleep,
    input logic               wake_out
);

    AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_req & mask_q) == '0) |-> (evt_line == '0)); // R1

    AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> ($stable(mask_q) && $stable(wake_q))); // R4

    AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !core_asleep |-> !wake_out); // R5

    AST_WAKE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_req & wake_q) == '0) |-> !wake_out); // R5

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        AST_RISE_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_line[g]) |-> ##2 evt_pend[g]); // R6

        AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (evt_pend[g] && !$rose(evt_ack[g])) |=> evt_pend[g]); // R7

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(evt_ack[g]) && !($past(evt_line[g]) && !$past(evt_line[g], 2)))
            |=> !evt_pend[g]); // R7
    end

endmodule

bind irq_aggregator irq_agg_chk #(.NUM_SRC(NUM_SRC), .NUM_EVT(NUM_EVT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .periph_req  (periph_req),
    .mask_q      (mask_q),
    .wake_q      (wake_q),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .evt_line    (evt_line),
    .evt_pend    (evt_pend),
    .evt_ack     (evt_ack),
    .core_asleep (core_asleep),
    .wake_out    (wake_out)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;

    localparam int NS = 8;
    localparam int NE = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] periph_req = '0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic [NE-1:0] evt_ack = '0;
    logic          core_asleep = 1'b0;
    logic [NE-1:0] evt_line;
    logic [NE-1:0] evt_pend;
    logic          wake_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_aggregator #(.NUM_SRC(NS), .NUM_EVT(NE)) uut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_ack(evt_ack), .core_asleep(core_asleep), .evt_line(evt_line),
        .evt_pend(evt_pend), .wake_out(wake_out)
    );

    // Reference model state, advanced at every rising edge.
    bit [NS-1:0] m_mask, m_wake;
    bit [NE-1:0] m_pend;
    int          line_hist [NE][$];
    bit [NE-1:0] m_ack_prev;

    function automatic bit [NE-1:0] exp_line(bit [NS-1:0] req, bit [NS-1:0] msk);
        bit [NE-1:0] r = '0;
        for (int s = 0; s < NS; s++) if (req[s] && msk[s]) r[s / 3] = 1'b1;
        return r;
    endfunction

    function automatic bit [NS-1:0] exp_rd(bit [1:0] a);
        case (a)
            2'd0: return m_mask;
            2'd1: return periph_req;
            2'd2: return m_wake;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Model update: rises seen one edge ago set pending; ack rising clears.
    always @(posedge clk) begin
        bit [NE-1:0] ln;
        ln = exp_line(periph_req, m_mask);
        if (!rst_n) begin
            m_mask = '0; m_wake = '0; m_pend = '0; m_ack_prev = '0;
            for (int e = 0; e < NE; e++) line_hist[e] = {0, 0};
        end else begin
            for (int e = 0; e < NE; e++) begin
                bit rose_before;
                rose_before = (line_hist[e][0] == 1) && (line_hist[e][1] == 0);
                if (rose_before) m_pend[e] = 1'b1;
                else if (evt_ack[e] && !m_ack_prev[e]) m_pend[e] = 1'b0;
                line_hist[e].push_front(int'(ln[e]));
                void'(line_hist[e].pop_back());
            end
            m_ack_prev = evt_ack;
            if (reg_wr && reg_addr == 2'd0) m_mask = reg_wdata;
            if (reg_wr && reg_addr == 2'd2) m_wake = reg_wdata;
        end
    end

    // Per-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1/R11 evt_line", evt_line, exp_line(periph_req, m_mask));
            chk("R6/R7/R8 evt_pend", evt_pend, m_pend);
            chk("R5 wake_out", wake_out, core_asleep && |(periph_req & m_wake));
            chk("R2/R3 reg_rdata", reg_rdata, exp_rd(reg_addr));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit [1:0] a, input bit [NS-1:0] d);
        tick(1);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input bit [1:0] a, input bit [NS-1:0] exp, input string tag);
        tick(1);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        periph_req = 8'hFF;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 evt_line after reset", evt_line, 3'b000);
        chk("R10 evt_pend after reset", evt_pend, 3'b000);
        chk("R10 mask after reset", reg_rdata, 8'h00);
        rd(2'd2, 8'h00, "R10 wake after reset");
        periph_req = '0;

        wr(2'd0, 8'hFF); rd(2'd0, 8'hFF, "R3 mask readback");
        wr(2'd2, 8'h0F); rd(2'd2, 8'h0F, "R3 wake readback");
        wr(2'd1, 8'h55);
        rd(2'd0, 8'hFF, "R4 mask after status write");
        rd(2'd2, 8'h0F, "R4 wake after status write");
        rd(2'd3, 8'h00, "R3 unused address");

        periph_req = 8'h81;
        rd(2'd1, 8'h81, "R2 status");
        wr(2'd0, 8'h01);
        rd(2'd1, 8'h81, "R2 status ignores mask");
        @(negedge clk); chk("R1 masked sources", evt_line, 3'b001);
        tick(1); periph_req = 8'h80;
        @(negedge clk); chk("R1 masked source blocked", evt_line, 3'b000);
        wr(2'd0, 8'hFF);
        tick(1); periph_req = 8'h10;
        @(negedge clk); chk("R11 source 4 to event 1", evt_line, 3'b010);
        tick(1); periph_req = 8'h40;
        @(negedge clk); chk("R11 source 6 to event 2", evt_line, 3'b100);
        tick(1); periph_req = 8'h04;
        @(negedge clk); chk("R11 source 2 to event 0", evt_line, 3'b001);

        // Flush pending bits with an acknowledge pulse.
        tick(1); periph_req = '0;
        tick(3); evt_ack = 3'b111;
        tick(1); evt_ack = 3'b000;
        tick(2);
        @(negedge clk); chk("R7 all cleared", evt_pend, 3'b000);

        // Rise on event 0, pending two edges later.
        tick(1); periph_req = 8'h01;
        @(negedge clk);
        @(negedge clk); chk("R6 one edge after rise", evt_pend[0], 1'b0);
        @(negedge clk); chk("R6 two edges after rise", evt_pend[0], 1'b1);
        repeat (4) begin
            @(negedge clk); chk("R7 held without ack", evt_pend[0], 1'b1);
        end
        tick(1); evt_ack = 3'b001;
        @(negedge clk); chk("R7 before ack edge", evt_pend[0], 1'b1);
        @(negedge clk); chk("R7 cleared by ack", evt_pend[0], 1'b0);
        repeat (3) begin
            @(negedge clk); chk("R9 steady level", evt_pend[0], 1'b0);
        end

        // New rise while ack stays high is queued.
        tick(1); periph_req = 8'h00;
        tick(1); periph_req = 8'h01;
        @(negedge clk);
        @(negedge clk); chk("R8 one edge after re-rise", evt_pend[0], 1'b0);
        @(negedge clk); chk("R8 queued during ack", evt_pend[0], 1'b1);
        repeat (2) begin
            @(negedge clk); chk("R8 held while ack high", evt_pend[0], 1'b1);
        end
        tick(1); evt_ack = 3'b000;
        tick(1); evt_ack = 3'b001;
        @(negedge clk);
        @(negedge clk); chk("R7 second ack clears", evt_pend[0], 1'b0);

        // Wakeup behaviour.
        tick(1); evt_ack = '0; periph_req = 8'h01; core_asleep = 1'b0;
        @(negedge clk); chk("R5 awake core", wake_out, 1'b0);
        tick(1); core_asleep = 1'b1;
        @(negedge clk); chk("R5 asleep, enabled source", wake_out, 1'b1);
        wr(2'd0, 8'h00);
        @(negedge clk); chk("R5 independent of mask", wake_out, 1'b1);
        tick(1); periph_req = 8'h10;
        @(negedge clk); chk("R5 source without wake enable", wake_out, 1'b0);

        // Reset in mid-run clears state.
        wr(2'd0, 8'hFF);
        tick(1); periph_req = 8'h01;
        tick(3);
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        @(negedge clk); chk("R10 pend after mid-run reset", evt_pend, 3'b000);
        rd(2'd0, 8'h00, "R10 mask after mid-run reset");
        rd(2'd2, 8'h00, "R10 wake after mid-run reset");

        tick(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule